// File: doc/BRIEF.md
# Peripheral Interrupt Register Bank

This block collects the interrupt sources of one peripheral inside a power-management chip. It samples a vector of raw interrupt lines. For each line it applies a trigger chosen by three configuration bits: a mode bit selects level or edge sensing, and two separate enables arm the high side and the low side. Detected events are held in a sticky status register. The sticky bits are gated with an enable mask, and the OR of the gated bits drives a single interrupt line toward the system.

Software reaches the block through a byte-wide register port with an 8-bit offset. Writes take effect on the clock edge. Reads are combinational. The enable mask has no direct write. Separate write-one-to-set and write-one-to-clear offsets change it, so a driver never needs a read-modify-write sequence. Sticky bits are cleared by writing ones. The block has no state machine. All state is held in plain registers that update every clock: the previous-input copy, the configuration registers, the enable mask and the sticky status.

Top module: `irqb_bank`

## Requirements
- R1: After reset, every configuration register, the enable mask, the sticky status, the master-select and priority fields all read 0, and `irq_out` is low.
- R2: With mode=1, high=1, low=0 on a line (rising edge), the sticky bit sets on the first clock where the input is 1 and was 0 on the previous clock. A steady level sets nothing. The offsets are mode 0x11, high-enable 0x12 and low-enable 0x13, and bit i of each register belongs to line i.
- R3: With mode=1, high=0, low=1 the line sets on a 1-to-0 transition. With mode=1, high=1, low=1 it sets on either transition.
- R4: With mode=0, high=1 the line sets on every clock where the input is 1. With mode=0, low=1 it sets on every clock where the input is 0. If the level is still active after a clear, the bit sets again on the next clock.
- R5: A write to 0x15 ORs the data into the enable mask. A write to 0x16 clears the mask bits where the data is 1, and 0xFF clears all of them. Reading 0x15 returns the mask.
- R6: A write to 0x14 clears the sticky bits (read at 0x18) where the data is 1 and leaves the others unchanged.
- R7: A sticky bit records an event whether or not the line is enabled. Offset 0x19 reads sticky AND enable, and `irq_out` is the OR of those bits.
- R8: Offset 0x10 returns the input lines as registered on the previous clock. Offsets 0x14, 0x16 and any unmapped offset read 0.
- R9: Offset 0x1A holds a 2-bit master-select field in bits 1:0. Offset 0x1B holds a priority flag in bit 0. All other bits of both registers read 0.
- R10: `bus_rdata` is 0 whenever `bus_rd` is low.
- R11: When a clear write to 0x14 and a new event on the same bit fall in the same clock, the event wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw | input | N_IRQ | Raw interrupt lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| irq_out | output | 1 | Peripheral interrupt, OR of pending bits |

## Verification
The bench builds the block with its default parameters: eight lines and an 8-bit offset. Every bit of every byte register is therefore a live interrupt line. This lets the bench place a rising, falling, both-edge, high-level and low-level trigger on separate lines at the same time, and it can write 0xFF to clear the whole enable mask in one access. The reference model is compared on every clock, so the one-clock delay of the previous-input copy and the case where an event and a clear meet on the same bit are both checked cycle by cycle.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
    localparam int DATA_W = 8;
    localparam int MSEL_W = 2;

    typedef enum logic [7:0] {
        OFS_RT    = 8'h10,
        OFS_MODE  = 8'h11,
        OFS_POLH  = 8'h12,
        OFS_POLL  = 8'h13,
        OFS_LCLR  = 8'h14,
        OFS_ENSET = 8'h15,
        OFS_ENCLR = 8'h16,
        OFS_LSTS  = 8'h18,
        OFS_PEND  = 8'h19,
        OFS_MSEL  = 8'h1A,
        OFS_PRIO  = 8'h1B
    } reg_ofs_e;
endpackage

// File: rtl/irqb_detect.sv
module irqb_detect #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] raw,
    input  logic [N_IRQ-1:0] cfg_mode,
    input  logic [N_IRQ-1:0] cfg_high,
    input  logic [N_IRQ-1:0] cfg_low,
    output logic [N_IRQ-1:0] raw_q,
    output logic [N_IRQ-1:0] evt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw;
    end

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        logic lvl_hit;
        logic edg_hit;
        assign lvl_hit = (cfg_high[i] & raw[i]) | (cfg_low[i] & ~raw[i]);
        assign edg_hit = (cfg_high[i] & raw[i] & ~raw_q[i]) |
                         (cfg_low[i] & ~raw[i] & raw_q[i]);
        assign evt[i]  = cfg_mode[i] ? edg_hit : lvl_hit;
    end

    // R2: an edge-mode line whose input did not move produces no event
    assert_edge_needs_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt & cfg_mode & ~(raw ^ raw_q)) == '0);

    // R4: an active high level in level mode always yields an event
    assert_level_high_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (~cfg_mode & cfg_high & raw & ~evt) == '0);
endmodule

// File: rtl/irqb_regs.sv
module irqb_regs
    import irqb_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_IRQ-1:0]  evt,
    output logic [N_IRQ-1:0]  cfg_mode,
    output logic [N_IRQ-1:0]  cfg_high,
    output logic [N_IRQ-1:0]  cfg_low,
    output logic [N_IRQ-1:0]  en,
    output logic [N_IRQ-1:0]  lat,
    output logic [MSEL_W-1:0] msel,
    output logic              prio
);
    logic [N_IRQ-1:0] wbits;
    logic [N_IRQ-1:0] clr_mask;

    assign wbits = wdata[N_IRQ-1:0];

    always_comb begin
        clr_mask = '0;
        if (wr_en && addr == ADDR_W'(OFS_LCLR)) clr_mask = wbits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_mode <= '0;
            cfg_high <= '0;
            cfg_low  <= '0;
            en       <= '0;
            msel     <= '0;
            prio     <= 1'b0;
        end else if (wr_en) begin
            unique case (addr)
                ADDR_W'(OFS_MODE):  cfg_mode <= wbits;
                ADDR_W'(OFS_POLH):  cfg_high <= wbits;
                ADDR_W'(OFS_POLL):  cfg_low  <= wbits;
                ADDR_W'(OFS_ENSET): en       <= en | wbits;
                ADDR_W'(OFS_ENCLR): en       <= en & ~wbits;
                ADDR_W'(OFS_MSEL):  msel     <= wdata[MSEL_W-1:0];
                ADDR_W'(OFS_PRIO):  prio     <= wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat <= '0;
        else        lat <= (lat & ~clr_mask) | evt;
    end

    assert_enset_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_ENSET)) |=>
            ((en & $past(wbits)) == $past(wbits)));

    assert_enclr_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_ENCLR)) |=> ((en & $past(wbits)) == '0));

    assert_lclr_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_LCLR)) |=>
            ((lat & $past(wbits) & ~$past(evt)) == '0));

    assert_lat_rises_on_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lat & ~$past(lat) & ~$past(evt)) == '0);
endmodule

// File: rtl/irqb_readmux.sv
module irqb_readmux
    import irqb_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int ADDR_W = 8
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_IRQ-1:0]  raw_q,
    input  logic [N_IRQ-1:0]  cfg_mode,
    input  logic [N_IRQ-1:0]  cfg_high,
    input  logic [N_IRQ-1:0]  cfg_low,
    input  logic [N_IRQ-1:0]  en,
    input  logic [N_IRQ-1:0]  lat,
    input  logic [N_IRQ-1:0]  pend,
    input  logic [MSEL_W-1:0] msel,
    input  logic              prio,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                ADDR_W'(OFS_RT):    rdata[N_IRQ-1:0]  = raw_q;
                ADDR_W'(OFS_MODE):  rdata[N_IRQ-1:0]  = cfg_mode;
                ADDR_W'(OFS_POLH):  rdata[N_IRQ-1:0]  = cfg_high;
                ADDR_W'(OFS_POLL):  rdata[N_IRQ-1:0]  = cfg_low;
                ADDR_W'(OFS_ENSET): rdata[N_IRQ-1:0]  = en;
                ADDR_W'(OFS_LSTS):  rdata[N_IRQ-1:0]  = lat;
                ADDR_W'(OFS_PEND):  rdata[N_IRQ-1:0]  = pend;
                ADDR_W'(OFS_MSEL):  rdata[MSEL_W-1:0] = msel;
                ADDR_W'(OFS_PRIO):  rdata[0]          = prio;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irqb_bank.sv
module irqb_bank
    import irqb_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_raw,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    logic [N_IRQ-1:0]  raw_q, evt, cfg_mode, cfg_high, cfg_low, en, lat, pend;
    logic [MSEL_W-1:0] msel;
    logic              prio;

    irqb_detect #(.N_IRQ(N_IRQ)) u_detect (
        .clk(clk), .rst_n(rst_n), .raw(irq_raw),
        .cfg_mode(cfg_mode), .cfg_high(cfg_high), .cfg_low(cfg_low),
        .raw_q(raw_q), .evt(evt)
    );

    irqb_regs #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .evt(evt), .cfg_mode(cfg_mode),
        .cfg_high(cfg_high), .cfg_low(cfg_low), .en(en), .lat(lat),
        .msel(msel), .prio(prio)
    );

    assign pend    = lat & en;
    assign irq_out = |pend;

    irqb_readmux #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W)) u_rdmux (
        .rd_en(bus_rd), .addr(bus_addr), .raw_q(raw_q),
        .cfg_mode(cfg_mode), .cfg_high(cfg_high), .cfg_low(cfg_low),
        .en(en), .lat(lat), .pend(pend), .msel(msel), .prio(prio),
        .rdata(bus_rdata)
    );

    // R7: the interrupt line only rises while some sticky bit is enabled
    assert_irq_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((lat & en) != '0));

    // R10: idle read port returns zero
    assert_idle_rdata_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/tb_irqb_bank.sv
module tb_irqb_bank;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_raw = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference state
    logic [7:0] m_mode = 0, m_hi = 0, m_lo = 0, m_en = 0, m_lat = 0, m_prev = 0;
    logic [1:0] m_msel = 0;
    logic       m_prio = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqb_bank dut (
        .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [7:0] model_read(input logic [7:0] a);
        case (a)
            8'h10: return m_prev;
            8'h11: return m_mode;
            8'h12: return m_hi;
            8'h13: return m_lo;
            8'h15: return m_en;
            8'h18: return m_lat;
            8'h19: return m_lat & m_en;
            8'h1A: return {6'b0, m_msel};
            8'h1B: return {7'b0, m_prio};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_clock(input logic wr, input logic [7:0] a,
                               input logic [7:0] d, input logic [7:0] raw);
        logic [7:0] ev;
        logic [7:0] clr;
        for (int i = 0; i < 8; i++) begin
            if (m_mode[i])
                ev[i] = (m_hi[i] && raw[i] && !m_prev[i]) || (m_lo[i] && !raw[i] && m_prev[i]);
            else
                ev[i] = (m_hi[i] && raw[i]) || (m_lo[i] && !raw[i]);
        end
        clr = (wr && a == 8'h14) ? d : 8'h00;
        m_lat = (m_lat & ~clr) | ev;
        if (wr) begin
            case (a)
                8'h11: m_mode = d;
                8'h12: m_hi = d;
                8'h13: m_lo = d;
                8'h15: m_en = m_en | d;
                8'h16: m_en = m_en & ~d;
                8'h1A: m_msel = d[1:0];
                8'h1B: m_prio = d[0];
                default: ;
            endcase
        end
        m_prev = raw;
    endtask

    // drive one cycle, compare at mid-low phase, then advance the model
    task automatic step(input string tag, input logic wr, input logic rd,
                        input logic [7:0] a, input logic [7:0] d, input logic [7:0] raw);
        logic [7:0] exp_rd;
        logic       exp_irq;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; irq_raw = raw;
        #1;
        exp_rd  = rd ? model_read(a) : 8'h00;
        exp_irq = |(m_lat & m_en);
        n_cmp++;
        if (bus_rdata !== exp_rd) begin
            n_bad++;
            $display("FAIL %s rdata addr=%02h actual=%02h expected=%02h", tag, a, bus_rdata, exp_rd);
        end
        n_cmp++;
        if (irq_out !== exp_irq) begin
            n_bad++;
            $display("FAIL %s irq_out actual=%b expected=%b", tag, irq_out, exp_irq);
        end
        @(posedge clk);
        model_clock(wr, a, d, raw);
        @(negedge clk);
    endtask

    task automatic wr(input string tag, input logic [7:0] a, input logic [7:0] d, input logic [7:0] raw);
        step(tag, 1'b1, 1'b0, a, d, raw);
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] raw);
        step(tag, 1'b0, 1'b1, a, 8'h00, raw);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 8'h10; a <= 8'h1B; a++) rd("R1_reset", 8'(a), 8'h00);

        // R9: master-select and priority widths
        wr("R9_msel", 8'h1A, 8'hFF, 8'h00);
        rd("R9_msel", 8'h1A, 8'h00);
        wr("R9_prio", 8'h1B, 8'hFE, 8'h00);
        rd("R9_prio", 8'h1B, 8'h00);
        wr("R9_prio", 8'h1B, 8'h01, 8'h00);
        rd("R9_prio", 8'h1B, 8'h00);

        // R2 rising on line0, R3 falling on line1 and both edges on line2
        wr("R2_cfg", 8'h11, 8'h07, 8'h00);
        wr("R2_cfg", 8'h12, 8'h05, 8'h00);
        wr("R3_cfg", 8'h13, 8'h06, 8'h00);
        rd("R2_cfg", 8'h11, 8'h00);
        rd("R2_steady", 8'h18, 8'h00);
        rd("R2_rise", 8'h18, 8'h07);
        rd("R2_hold", 8'h18, 8'h07);
        rd("R8_rt", 8'h10, 8'h07);
        wr("R6_clear", 8'h14, 8'hFF, 8'h07);
        rd("R2_nochange", 8'h18, 8'h07);
        rd("R3_fall", 8'h18, 8'h00);
        rd("R3_after", 8'h18, 8'h00);

        // R7: sticky without enable, then pending and irq_out
        rd("R7_pend_off", 8'h19, 8'h00);
        wr("R5_enset", 8'h15, 8'h02, 8'h00);
        rd("R7_pend", 8'h19, 8'h00);
        wr("R5_enset", 8'h15, 8'h04, 8'h00);
        rd("R5_enread", 8'h15, 8'h00);
        wr("R6_partial", 8'h14, 8'h02, 8'h00);
        rd("R6_partial", 8'h18, 8'h00);
        wr("R5_enclr", 8'h16, 8'h04, 8'h00);
        rd("R7_irq_low", 8'h19, 8'h00);
        wr("R5_enset", 8'h15, 8'hF0, 8'h00);
        wr("R5_enclr_all", 8'h16, 8'hFF, 8'h00);
        rd("R5_enclr_all", 8'h15, 8'h00);
        wr("R6_clear", 8'h14, 8'hFF, 8'h00);

        // R4: level high on line3, level low on line4
        wr("R4_cfg", 8'h12, 8'h0D, 8'h00);
        wr("R4_cfg", 8'h13, 8'h16, 8'h00);
        wr("R5_enset", 8'h15, 8'h18, 8'h08);
        rd("R4_level", 8'h18, 8'h08);
        wr("R4_reset_again", 8'h14, 8'h18, 8'h08);
        rd("R4_reset_again", 8'h18, 8'h18);
        wr("R4_released", 8'h14, 8'h18, 8'h10);
        rd("R4_released", 8'h18, 8'h10);
        wr("R6_clear", 8'h14, 8'hFF, 8'h10);
        rd("R6_cleared", 8'h18, 8'h10);
        wr("R6_clear", 8'h14, 8'hFF, 8'h10);

        // R11: clear and rising edge meet on line0
        rd("R11_prep", 8'h18, 8'h10);
        wr("R11_collide", 8'h14, 8'h01, 8'h11);
        rd("R11_collide", 8'h18, 8'h11);

        // R8: reads of write-only and unmapped offsets
        rd("R8_lclr", 8'h14, 8'h11);
        rd("R8_enclr", 8'h16, 8'h11);
        rd("R8_gap", 8'h17, 8'h11);
        rd("R8_low", 8'h00, 8'h11);
        rd("R8_high", 8'hFF, 8'h11);

        // R10: read strobe low
        step("R10_idle", 1'b0, 1'b0, 8'h18, 8'h00, 8'h11);
        step("R10_idle", 1'b0, 1'b0, 8'h11, 8'h00, 8'h00);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule